// File: doc/BRIEF.md
# Double-Buffered Endpoint Packet Buffer

This block holds outgoing packet data for one data endpoint of a serial-bus peripheral. A local processor writes bytes, 8 or 16 bits per write, into whichever of the two packet buffers is active. The block counts the bytes as they arrive. It commits the active buffer to the packet side on any of three events: the count reaches the configured maximum packet size; the count reaches a shorter length that the processor loaded into the data-count register; or the processor issues a validate command. After a commit, writing moves to the other buffer. The packet side drains committed buffers one byte at a time, in commit order.

The same data-count register also serves the receive direction. When the packet engine acknowledges a received packet, it supplies that packet's byte count, and the block loads it into the register. The block then raises a one-cycle endpoint event. It raises the same event when the packet side finishes draining a buffer. A two-bit status output shows which buffers hold committed packets. When both bits are set, the processor must hold off further writes.

Top module: `ep_pkt_buffer`

## Requirements
- R1: After reset, `dcount` is 0, `buf_full` is 2'b00, `pkt_avail` is 0 and `ep_irq` is 0.
- R2: When `dcount` is 0 or not below `cfg_max`, the active buffer commits on the clock edge that stores its `cfg_max`-th byte. Its `buf_full` bit is set after that edge and its `pkt_len` equals `cfg_max`.
- R3: When `dcount` is nonzero and below `cfg_max`, the buffer commits once `dcount` bytes are stored, with `pkt_len` = `dcount`. `dcount` returns to 0 on that same edge.
- R4: `cpu_validate` commits the active buffer with the bytes stored so far, including a write in the same cycle. A buffer with no bytes commits as a zero-length packet.
- R5: With `cpu_wide` = 1, a write stores `cpu_wdata[7:0]` at the next index and `cpu_wdata[15:8]` at the index after it. When only one byte remains before the commit length, only the low lane is stored and the count advances by one.
- R6: Commits go to buffer 0 first and then alternate. `buf_full[i]` = 1 means buffer i holds a committed packet. The packet side sees the packets in commit order.
- R7: A write or validate while the active buffer is full is ignored: no byte is stored and the count is unchanged.
- R8: `pkt_byte` shows the byte at the read position of the oldest committed buffer. A `pkt_rd` on its last byte, or on a zero-length packet, frees that buffer and clears its `buf_full` bit. `ep_irq` is then high for exactly the following cycle.
- R9: `out_ack` loads `dcount` with `out_len` and raises `ep_irq` for the following cycle.
- R10: `bus_rst` clears `dcount`, both buffers, the write count and both buffer pointers. The next commit goes to buffer 0.
- R11: `cpu_len_wr` loads `dcount` from `cpu_len_wdata`. When `out_ack` occurs in the same cycle, `out_len` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset |
| bus_rst | input | 1 | Synchronous bus reset |
| cfg_max | input | 16 | Maximum packet size in bytes |
| cpu_wr | input | 1 | Processor data write strobe |
| cpu_wide | input | 1 | Write carries two byte lanes |
| cpu_wdata | input | 16 | Write data, low lane first |
| cpu_validate | input | 1 | Commit the active buffer now |
| cpu_len_wr | input | 1 | Load the data-count register |
| cpu_len_wdata | input | 16 | Value for the data-count register |
| dcount | output | 16 | Data-count register |
| buf_full | output | 2 | Per-buffer committed-packet flags |
| out_ack | input | 1 | Received packet acknowledged |
| out_len | input | 16 | Byte count of the received packet |
| pkt_avail | output | 1 | A committed packet is ready to drain |
| pkt_len | output | 16 | Length of the packet being drained |
| pkt_byte | output | 8 | Byte at the current read position |
| pkt_rd | input | 1 | Consume one byte (or an empty packet) |
| ep_irq | output | 1 | One-cycle endpoint event |

## Verification
Committing the active buffer and freeing the other buffer can happen on the same clock edge. When they do, both status bits change at once: one is set and the other cleared. The bench fills one buffer and drains all but one byte of it. It fills the second buffer to one byte short, then drives the final write and the final read in the same cycle. It expects `buf_full` to show only the newly committed buffer, `ep_irq` to pulse, and the new packet's length and bytes to be intact. A second collision, `out_ack` against `cpu_len_wr`, is judged by which value lands in `dcount`.

// File: rtl/ep_pkg.sv
package ep_pkg;
  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  // a programmed short length applies only when nonzero and below max size
  function automatic logic short_active(cnt_t dcnt, cnt_t maxp);
    return (dcnt != '0) && (dcnt < maxp);
  endfunction

  // commit length: short length or max size, bounded by storage, at least 1
  function automatic cnt_t pick_limit(cnt_t dcnt, cnt_t maxp, cnt_t cap);
    cnt_t l;
    l = short_active(dcnt, maxp) ? dcnt : maxp;
    if (l > cap) l = cap;
    if (l == '0) l = cnt_t'(1);
    return l;
  endfunction

  // bytes accepted by one write
  function automatic cnt_t step_bytes(logic wide, cnt_t cnt, cnt_t lim);
    return (wide && (cnt + cnt_t'(1) < lim)) ? cnt_t'(2) : cnt_t'(1);
  endfunction
endpackage

// File: rtl/ep_count_reg.sv
module ep_count_reg
  import ep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst,
  input  logic out_ack,
  input  cnt_t out_len,
  input  logic len_wr,
  input  cnt_t len_wdata,
  input  logic clr_short,
  output cnt_t dcount
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dcount <= '0;
    else if (bus_rst)   dcount <= '0;
    else if (out_ack)   dcount <= out_len;
    else if (len_wr)    dcount <= len_wdata;
    else if (clr_short) dcount <= '0;
  end

  // R10
  bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> dcount == '0);
  // R9
  out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ack && !bus_rst) |=> dcount == $past(out_len));
endmodule

// File: rtl/ep_wr_ctrl.sv
module ep_wr_ctrl
  import ep_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rst,
  input  logic          cpu_wr,
  input  logic          cpu_wide,
  input  logic          cpu_validate,
  input  cnt_t          dcnt,
  input  cnt_t          maxp,
  input  logic [1:0]    buf_full,
  output logic          wr_buf,
  output logic [AW-1:0] wr_addr,
  output logic          wr_store,
  output logic          wr_two,
  output logic          commit,
  output cnt_t          commit_len,
  output logic          commit_short
);
  cnt_t cnt_q, lim, step, cnt_next;
  logic blocked, auto_hit;

  assign lim      = pick_limit(dcnt, maxp, cnt_t'(BUF_BYTES));
  assign blocked  = buf_full[wr_buf];
  assign wr_store = cpu_wr && !blocked;
  assign step     = step_bytes(cpu_wide, cnt_q, lim);
  assign wr_two   = wr_store && (step == cnt_t'(2));
  assign cnt_next = wr_store ? cnt_q + step : cnt_q;
  assign auto_hit = wr_store && (cnt_next >= lim);
  assign commit   = !blocked && (auto_hit || cpu_validate);
  assign commit_len   = cnt_next;
  assign commit_short = auto_hit && short_active(dcnt, maxp);
  assign wr_addr  = cnt_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wr_buf <= 1'b0;
    end else if (bus_rst) begin
      cnt_q  <= '0;
      wr_buf <= 1'b0;
    end else if (commit) begin
      cnt_q  <= '0;
      wr_buf <= ~wr_buf;
    end else begin
      cnt_q  <= cnt_next;
    end
  end

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < cnt_t'(BUF_BYTES));
  // R7
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    (blocked && (cpu_wr || cpu_validate)) |=> $stable(cnt_q) && $stable(wr_buf));
endmodule

// File: rtl/ep_rd_ctrl.sv
module ep_rd_ctrl
  import ep_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rst,
  input  logic          pkt_rd,
  input  logic [1:0]    buf_full,
  input  cnt_t          len0,
  input  cnt_t          len1,
  output logic          rd_buf,
  output logic [AW-1:0] rd_addr,
  output cnt_t          cur_len,
  output logic          release_ev
);
  cnt_t ptr_q;
  logic take, last;

  assign cur_len    = rd_buf ? len1 : len0;
  assign take       = pkt_rd && buf_full[rd_buf];
  assign last       = (cur_len == '0) || (ptr_q + cnt_t'(1) >= cur_len);
  assign release_ev = take && last;
  assign rd_addr    = ptr_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      rd_buf <= 1'b0;
    end else if (bus_rst) begin
      ptr_q  <= '0;
      rd_buf <= 1'b0;
    end else if (release_ev) begin
      ptr_q  <= '0;
      rd_buf <= ~rd_buf;
    end else if (take) begin
      ptr_q  <= ptr_q + cnt_t'(1);
    end
  end

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    (!buf_full[rd_buf]) |=> $stable(ptr_q) && $stable(rd_buf));
endmodule

// File: rtl/ep_pkt_buffer.sv
module ep_pkt_buffer
  import ep_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rst,
  input  logic [15:0] cfg_max,
  input  logic        cpu_wr,
  input  logic        cpu_wide,
  input  logic [15:0] cpu_wdata,
  input  logic        cpu_validate,
  input  logic        cpu_len_wr,
  input  logic [15:0] cpu_len_wdata,
  output logic [15:0] dcount,
  output logic [1:0]  buf_full,
  input  logic        out_ack,
  input  logic [15:0] out_len,
  output logic        pkt_avail,
  output logic [15:0] pkt_len,
  output logic [7:0]  pkt_byte,
  input  logic        pkt_rd,
  output logic        ep_irq
);
  logic          wr_buf, wr_store, wr_two, commit, commit_short;
  logic [AW-1:0] wr_addr, rd_addr;
  cnt_t          commit_len, len_q [2];
  logic          rd_buf, release_ev;
  logic [7:0]    mem [2][BUF_BYTES];

  ep_count_reg u_cnt (
    .clk, .rst_n, .bus_rst, .out_ack, .out_len,
    .len_wr(cpu_len_wr), .len_wdata(cpu_len_wdata),
    .clr_short(commit_short), .dcount
  );

  ep_wr_ctrl #(.BUF_BYTES(BUF_BYTES)) u_wr (
    .clk, .rst_n, .bus_rst, .cpu_wr, .cpu_wide, .cpu_validate,
    .dcnt(dcount), .maxp(cfg_max), .buf_full,
    .wr_buf, .wr_addr, .wr_store, .wr_two, .commit, .commit_len, .commit_short
  );

  ep_rd_ctrl #(.BUF_BYTES(BUF_BYTES)) u_rd (
    .clk, .rst_n, .bus_rst, .pkt_rd, .buf_full,
    .len0(len_q[0]), .len1(len_q[1]),
    .rd_buf, .rd_addr, .cur_len(pkt_len), .release_ev
  );

  always_ff @(posedge clk) begin
    if (wr_store) mem[wr_buf][wr_addr] <= cpu_wdata[7:0];
    if (wr_two)   mem[wr_buf][wr_addr + AW'(1)] <= cpu_wdata[15:8];
  end

  for (genvar i = 0; i < 2; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_full[i] <= 1'b0;
        len_q[i]    <= '0;
      end else if (bus_rst) begin
        buf_full[i] <= 1'b0;
        len_q[i]    <= '0;
      end else if (commit && (wr_buf == i[0])) begin
        buf_full[i] <= 1'b1;
        len_q[i]    <= commit_len;
      end else if (release_ev && (rd_buf == i[0])) begin
        buf_full[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ep_irq <= 1'b0;
    else if (bus_rst) ep_irq <= 1'b0;
    else              ep_irq <= out_ack || release_ev;
  end

  assign pkt_avail = buf_full[rd_buf];
  assign pkt_byte  = mem[rd_buf][rd_addr];

  // R6
  commit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    commit |=> buf_full[$past(wr_buf)]);
  // R8
  release_irq_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    release_ev |=> ep_irq && !buf_full[$past(rd_buf)]);
  // R9
  ack_irq_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    out_ack |=> ep_irq);
endmodule

// File: tb/test_ep_pkt_buffer.sv
`timescale 1ns/1ps
module test_ep_pkt_buffer;
  logic clk = 0, rst_n = 0, bus_rst = 0;
  logic [15:0] cfg_max = 16'd8;
  logic cpu_wr = 0, cpu_wide = 0, cpu_validate = 0, cpu_len_wr = 0;
  logic [15:0] cpu_wdata = 0, cpu_len_wdata = 0;
  logic [15:0] dcount, pkt_len, out_len = 0;
  logic [1:0]  buf_full;
  logic out_ack = 0, pkt_avail, pkt_rd = 0, ep_irq;
  logic [7:0]  pkt_byte;
  int checks = 0, fails = 0;
  bit done = 0;
  logic exp_wb = 0, exp_rb = 0;

  always #2 clk = ~clk;

  ep_pkt_buffer i_ep_pkt_buffer (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic w, logic [7:0] lo, logic [7:0] hi);
    @(negedge clk); cpu_wr = 1; cpu_wide = w; cpu_wdata = {hi, lo};
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic rd();
    @(negedge clk); pkt_rd = 1;
    @(negedge clk); pkt_rd = 0;
  endtask

  // write lim bytes; byte i carries base+i; stops before the final write if hold
  task automatic fill(int lim, logic w, logic [7:0] base, bit hold);
    int c = 0;
    while (c < lim) begin
      int s = (w && c + 1 < lim) ? 2 : 1;
      if (hold && c + s >= lim) break;
      wr(w, base + 8'(c), base + 8'(c + 1));
      c += s;
    end
  endtask

  task automatic drain(string req, int len, logic [7:0] base);
    chk({req, " avail"}, pkt_avail, 1);
    chk({req, " len"}, pkt_len, len);
    if (len == 0) rd();
    for (int i = 0; i < len; i++) begin
      chk({req, " byte"}, pkt_byte, base + 8'(i));
      rd();
    end
    chk("R8 irq pulse", ep_irq, 1);
    chk("R8 bit cleared", buf_full[exp_rb], 0);
    exp_rb = ~exp_rb;
    @(negedge clk);
    chk("R8 irq one cycle", ep_irq, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dcount", dcount, 0);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 avail", pkt_avail, 0);
    chk("R1 irq", ep_irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R5 R6 sweep over max size and lane width
    for (int w = 0; w < 2; w++) begin
      for (int mp = 1; mp <= 9; mp++) begin
        cfg_max = 16'(mp);
        fill(mp, w[0], 8'(mp * 16 + w), 0);
        chk("R2 commit at max", buf_full[exp_wb], 1);
        chk("R6 alternation", buf_full[~exp_wb], 0);
        exp_wb = ~exp_wb;
        drain(w ? "R5 wide" : "R2 narrow", mp, 8'(mp * 16 + w));
      end
    end

    // R3 short length
    cfg_max = 16'd8;
    @(negedge clk); cpu_len_wr = 1; cpu_len_wdata = 16'd5;
    @(negedge clk); cpu_len_wr = 0;
    chk("R11 load", dcount, 5);
    fill(5, 1, 8'h40, 0);
    chk("R3 commit", buf_full[exp_wb], 1);
    chk("R3 dcount cleared", dcount, 0);
    exp_wb = ~exp_wb;
    drain("R3 short", 5, 8'h40);

    // R4 manual validate, two bytes then zero bytes
    wr(0, 8'h60, 0); wr(0, 8'h61, 0);
    chk("R4 not yet", buf_full, 0);
    @(negedge clk); cpu_validate = 1;
    @(negedge clk); cpu_validate = 0;
    chk("R4 commit", buf_full[exp_wb], 1);
    exp_wb = ~exp_wb;
    drain("R4 validate", 2, 8'h60);
    @(negedge clk); cpu_validate = 1;
    @(negedge clk); cpu_validate = 0;
    chk("R4 zero commit", buf_full[exp_wb], 1);
    exp_wb = ~exp_wb;
    drain("R4 zero length", 0, 0);

    // R7 both full, extra writes ignored
    cfg_max = 16'd2;
    fill(2, 0, 8'h70, 0); exp_wb = ~exp_wb;
    fill(2, 0, 8'h80, 0); exp_wb = ~exp_wb;
    chk("R7 both full", buf_full, 2'b11);
    wr(1, 8'hEE, 8'hEF);
    @(negedge clk); cpu_validate = 1;
    @(negedge clk); cpu_validate = 0;
    chk("R7 still full", buf_full, 2'b11);
    drain("R7 first", 2, 8'h70);
    fill(2, 0, 8'h90, 0);
    chk("R7 refill commit", buf_full, 2'b11);
    exp_wb = ~exp_wb;
    drain("R7 second", 2, 8'h80);
    drain("R7 ignored writes absent", 2, 8'h90);

    // collision: final write and final read in one cycle
    cfg_max = 16'd4;
    fill(4, 0, 8'hA0, 0); exp_wb = ~exp_wb;
    fill(4, 0, 8'hB0, 1);
    for (int i = 0; i < 3; i++) rd();
    @(negedge clk); cpu_wr = 1; cpu_wide = 0; cpu_wdata = 16'h00B3; pkt_rd = 1;
    @(negedge clk); cpu_wr = 0; pkt_rd = 0;
    chk("R8 collision status", buf_full, exp_wb ? 2'b10 : 2'b01);
    chk("R8 collision irq", ep_irq, 1);
    exp_rb = ~exp_rb; exp_wb = ~exp_wb;
    @(negedge clk);
    drain("R6 collision packet", 4, 8'hB0);

    // R9 and R11 priority
    @(negedge clk); out_ack = 1; out_len = 16'h1234; cpu_len_wr = 1; cpu_len_wdata = 16'h0003;
    @(negedge clk); out_ack = 0; cpu_len_wr = 0;
    chk("R9 dcount", dcount, 16'h1234);
    chk("R11 priority", dcount, 16'h1234);
    chk("R9 irq", ep_irq, 1);
    @(negedge clk);
    chk("R9 irq one cycle", ep_irq, 0);

    // R10 bus reset mid-packet
    cfg_max = 16'd4;
    wr(0, 8'h11, 0);
    fill(4, 0, 8'hC0, 0);
    @(negedge clk); bus_rst = 1;
    @(negedge clk); bus_rst = 0;
    chk("R10 dcount", dcount, 0);
    chk("R10 buf_full", buf_full, 0);
    chk("R10 avail", pkt_avail, 0);
    exp_wb = 0; exp_rb = 0;
    fill(4, 1, 8'hD0, 0);
    chk("R10 restart buffer 0", buf_full, 2'b01);
    exp_wb = 1;
    drain("R10 restart packet", 4, 8'hD0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule